// File: doc/BRIEF.md
# Performance Counter Freeze-on-Interrupt Controller

This block is a compact performance-monitoring unit. It holds two general-purpose event counters and three fixed-function counters, each 48 bits wide. Every counter is gated by its own bit in a global enable register and advances by one in each cycle in which that bit is set and its event input is high. Software uses a small register bus to program the interrupt enables, preload or read the counters, arm counting and clear the sticky overflow flags.

A counter that wraps, with its overflow interrupt enabled, triggers a freeze. A rising edge on either trace-buffer threshold input also triggers a freeze. On the clock edge that detects the trigger, the block clears every global enable bit and raises `pmi_irq` for exactly one cycle. All counting then stays stopped until software writes 1s back into the enable register.

A three-state machine follows this sequence:

- `FZ_RUN` is normal operation.
- `FZ_PULSE` is the single cycle in which the interrupt is high. It is entered from any state on a trigger.
- `FZ_HALT` means frozen and waiting.

The transitions are as follows:

- `FZ_PULSE` goes back to itself on a further trigger, to `FZ_RUN` on a re-arming write, and to `FZ_HALT` otherwise.
- `FZ_HALT` leaves to `FZ_PULSE` on a trigger or to `FZ_RUN` on a re-arming write.

A re-arming write is a write to the enable register with at least one enable bit set.

Top module: `pmu_freeze_ctrl`

## Requirements
- R1: After reset, all counters, the enable register, the overflow status, both event-select registers and the fixed control register read zero, and `pmi_irq` is low.
- R2: A counter increments by one on each clock edge where its enable bit is 1 and its event input is high; otherwise it holds. The enable bit is bit i for general-purpose counter i and bit 32+j for fixed counter j.
- R3: When a counter wraps from all-ones to zero, the status bit at the same position as its enable bit becomes 1 on that same edge. It stays 1 until cleared through the clear register.
- R4: A general-purpose counter wrap with bit 20 of its event-select register set drives `pmi_irq` high for exactly one cycle after the wrap edge, and reads of the enable register return zero from then on.
- R5: Fixed counter j uses a 4-bit field at bits 4j+3..4j of the fixed control register. Its wrap triggers the freeze only when bit 4j+3 is set; the other three field bits never trigger it.
- R6: A wrap without its interrupt enable sets the status bit but causes no interrupt and leaves the enables unchanged.
- R7: A rising edge on `sample_buf_hit` freezes and pulses `pmi_irq` once, and it sets status bit 62. Holding the input high gives no further pulse.
- R8: A rising edge on `branch_buf_hit` has the same effect as in R7, including status bit 62.
- R9: While frozen, counters ignore their event inputs. Counting resumes on the edge after software writes the enable bits back to 1.
- R10: A write to the clear register clears each status bit whose data bit is 1 and leaves every other status bit unchanged.
- R11: When a write to the enable register and a trigger fall on the same edge, the enables become zero and the interrupt still pulses.
- R12: The register map is:
  - address i (i < 2): event-select register of general-purpose counter i, 32 bits, read/write;
  - address 4: fixed control register, 12 bits;
  - address 5: enable register, which reads back only bits 0, 1 and 32..34;
  - address 6: overflow status;
  - address 7: clear register;
  - address 8+k: counter k, with the general-purpose counters first. Counters are loadable by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data (combinational on `bus_addr`) |
| gp_event | input | 2 | Event inputs of the general-purpose counters |
| fix_event | input | 3 | Event inputs of the fixed counters |
| sample_buf_hit | input | 1 | Sampling-record buffer at its interrupt threshold |
| branch_buf_hit | input | 1 | Branch-trace buffer at its interrupt threshold |
| pmi_irq | output | 1 | Monitoring interrupt, one-cycle pulse per trigger |

## Verification
The assertions check the following on every cycle:

- every trigger is followed by a zeroed enable register and an interrupt pulse;
- no pulse appears without a trigger, and no pulse lasts past its cycle unless a new trigger arrives;
- set status bits never drop except through the clear register;
- a frozen enable register stays zero until software writes it.

The cycle at which a 48-bit counter wraps, which field bits gate the fixed-counter interrupt, the held-level threshold behaviour, selective clearing and the same-edge write collision can only be shown by the directed scenarios.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int REG_W        = 64;
    localparam int ADDR_W       = 4;
    localparam int GP_INT_BIT   = 20;
    localparam int FIX_FIELD_W  = 4;
    localparam int FIX_INT_BIT  = 3;
    localparam int FIX_BASE     = 32;
    localparam int BUF_OVF_BIT  = 62;

    localparam logic [ADDR_W-1:0] ADDR_FIX_CTRL = 4'd4;
    localparam logic [ADDR_W-1:0] ADDR_GLB_EN   = 4'd5;
    localparam logic [ADDR_W-1:0] ADDR_OVF_STAT = 4'd6;
    localparam logic [ADDR_W-1:0] ADDR_OVF_CLR  = 4'd7;
    localparam int                ADDR_CNT_BASE = 8;

    typedef enum logic [1:0] {
        FZ_RUN   = 2'd0,
        FZ_PULSE = 2'd1,
        FZ_HALT  = 2'd2
    } frz_state_t;

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ld,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] value,
    output logic             wrap
);

    // A software load on the same edge wins over counting, so no wrap is reported then.
    assign wrap = inc && !ld && (&value);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (ld) begin
            value <= ld_val;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/pmu_freeze_fsm.sv
module pmu_freeze_fsm
    import pmu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic rearm,
    output logic irq
);

    frz_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FZ_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            FZ_RUN: begin
                if (trigger) state_nx = FZ_PULSE;
            end
            FZ_PULSE: begin
                if (trigger)    state_nx = FZ_PULSE;
                else if (rearm) state_nx = FZ_RUN;
                else            state_nx = FZ_HALT;
            end
            FZ_HALT: begin
                if (trigger)    state_nx = FZ_PULSE;
                else if (rearm) state_nx = FZ_RUN;
            end
            default: state_nx = FZ_RUN;
        endcase
    end

    always_comb begin
        unique case (state)
            FZ_PULSE: irq = 1'b1;
            default:  irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmu_freeze_ctrl.sv
module pmu_freeze_ctrl
    import pmu_pkg::*;
#(
    parameter int CNT_W   = 48,
    parameter int NUM_GP  = 2,
    parameter int NUM_FIX = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NUM_GP-1:0] gp_event,
    input  logic [NUM_FIX-1:0] fix_event,
    input  logic              sample_buf_hit,
    input  logic              branch_buf_hit,
    output logic              pmi_irq
);

    localparam int NUM_CNT    = NUM_GP + NUM_FIX;
    localparam int FIX_CTRL_W = NUM_FIX * FIX_FIELD_W;

    function automatic int cnt_bit(input int k);
        return (k < NUM_GP) ? k : FIX_BASE + k - NUM_GP;
    endfunction

    function automatic logic [REG_W-1:0] make_en_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_CNT; k++) m[cnt_bit(k)] = 1'b1;
        return m;
    endfunction

    localparam logic [REG_W-1:0] EN_MASK   = make_en_mask();
    localparam logic [REG_W-1:0] STAT_MASK = EN_MASK | (64'd1 << BUF_OVF_BIT);

    logic [31:0]           gp_sel [NUM_GP];
    logic [FIX_CTRL_W-1:0] fix_ctrl;
    logic [REG_W-1:0]      glb_en;
    logic [REG_W-1:0]      ovf_stat;
    logic [1:0]            buf_prev;

    logic [CNT_W-1:0]      cnt_val [NUM_CNT];
    logic [NUM_CNT-1:0]    cnt_wrap, cnt_int_en, cnt_event;
    logic [1:0]            buf_hit, buf_rise;
    logic [REG_W-1:0]      ovf_set, ovf_clr;
    logic                  trigger, rearm, glb_wr;

    assign glb_wr   = bus_we && (bus_addr == ADDR_GLB_EN);
    assign rearm    = glb_wr && |(bus_wdata & EN_MASK);
    assign buf_hit  = {branch_buf_hit, sample_buf_hit};
    assign buf_rise = buf_hit & ~buf_prev;
    assign trigger  = |(cnt_wrap & cnt_int_en) || |buf_rise;
    assign ovf_clr  = (bus_we && bus_addr == ADDR_OVF_CLR) ? (bus_wdata & STAT_MASK) : '0;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam int EN_BIT = cnt_bit(i);
        if (i < NUM_GP) begin : g_gp
            assign cnt_event[i]  = gp_event[i];
            assign cnt_int_en[i] = gp_sel[i][GP_INT_BIT];
        end else begin : g_fix
            assign cnt_event[i]  = fix_event[i-NUM_GP];
            assign cnt_int_en[i] = fix_ctrl[(i-NUM_GP)*FIX_FIELD_W + FIX_INT_BIT];
        end
        pmu_counter #(.WIDTH(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (glb_en[EN_BIT] & cnt_event[i]),
            .ld     (bus_we && bus_addr == ADDR_W'(ADDR_CNT_BASE + i)),
            .ld_val (bus_wdata[CNT_W-1:0]),
            .value  (cnt_val[i]),
            .wrap   (cnt_wrap[i])
        );
    end

    for (genvar i = 0; i < NUM_GP; i++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                gp_sel[i] <= '0;
            end else if (bus_we && bus_addr == ADDR_W'(i)) begin
                gp_sel[i] <= bus_wdata[31:0];
            end
        end
    end

    always_comb begin
        ovf_set = '0;
        for (int k = 0; k < NUM_CNT; k++) ovf_set[cnt_bit(k)] = cnt_wrap[k];
        ovf_set[BUF_OVF_BIT] = |buf_rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fix_ctrl <= '0;
            glb_en   <= '0;
            ovf_stat <= '0;
            buf_prev <= '0;
        end else begin
            if (bus_we && bus_addr == ADDR_FIX_CTRL) fix_ctrl <= bus_wdata[FIX_CTRL_W-1:0];
            if (trigger)     glb_en <= '0;
            else if (glb_wr) glb_en <= bus_wdata & EN_MASK;
            ovf_stat <= (ovf_stat & ~ovf_clr) | ovf_set;
            buf_prev <= buf_hit;
        end
    end

    pmu_freeze_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (trigger),
        .rearm   (rearm),
        .irq     (pmi_irq)
    );

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_GP; k++)
            if (bus_addr == ADDR_W'(k)) bus_rdata = {32'd0, gp_sel[k]};
        for (int k = 0; k < NUM_CNT; k++)
            if (bus_addr == ADDR_W'(ADDR_CNT_BASE + k))
                bus_rdata = {{(REG_W-CNT_W){1'b0}}, cnt_val[k]};
        if (bus_addr == ADDR_FIX_CTRL) bus_rdata = {{(REG_W-FIX_CTRL_W){1'b0}}, fix_ctrl};
        if (bus_addr == ADDR_GLB_EN)   bus_rdata = glb_en;
        if (bus_addr == ADDR_OVF_STAT) bus_rdata = ovf_stat;
    end

endmodule

// File: rtl/pmu_freeze_ctrl_chk.sv
module pmu_freeze_ctrl_chk
    import pmu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              trigger,
    input logic              pmi_irq,
    input logic [REG_W-1:0]  glb_en,
    input logic [REG_W-1:0]  ovf_stat
);

    // R4
    trig_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> pmi_irq);

    // R4
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pmi_irq |-> $past(trigger));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmi_irq && !trigger) |=> !pmi_irq);

    // R11
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> (glb_en == '0));

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == ADDR_OVF_CLR)
        |=> ((ovf_stat & $past(ovf_stat)) == $past(ovf_stat)));

    // R9
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en == '0 && !(bus_we && bus_addr == ADDR_GLB_EN)) |=> (glb_en == '0));

endmodule

bind pmu_freeze_ctrl pmu_freeze_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .trigger  (trigger),
    .pmi_irq  (pmi_irq),
    .glb_en   (glb_en),
    .ovf_stat (ovf_stat)
);

// File: tb/pmu_freeze_ctrl_tb.sv
module pmu_freeze_ctrl_tb;

    localparam logic [47:0] ALL1 = 48'hFFFF_FFFF_FFFF;
    localparam logic [3:0] A_SEL0 = 4'd0, A_SEL1 = 4'd1, A_FIX = 4'd4, A_GLB = 4'd5,
                           A_STAT = 4'd6, A_CLR = 4'd7, A_C0 = 4'd8, A_C1 = 4'd9,
                           A_F0 = 4'd10, A_F1 = 4'd11, A_F2 = 4'd12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [1:0]  gp_event = '0;
    logic [2:0]  fix_event = '0;
    logic        sample_buf_hit = 1'b0;
    logic        branch_buf_hit = 1'b0;
    logic        pmi_irq;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;

    always #4 clk = ~clk;

    pmu_freeze_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gp_event(gp_event),
        .fix_event(fix_event), .sample_buf_hit(sample_buf_hit),
        .branch_buf_hit(branch_buf_hit), .pmi_irq(pmi_irq)
    );

    always @(negedge clk) if (rst_n && pmi_irq) irq_seen++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [63:0] v;
        rd(A_GLB, v);  chk("R1 enables", v, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        rd(A_C0, v);   chk("R1 counter0", v, 0);
        rd(A_F2, v);   chk("R1 fixed2", v, 0);
        rd(A_SEL0, v); chk("R1 select0", v, 0);
        chk("R1 irq", {63'd0, pmi_irq}, 0);
    endtask

    task automatic t_regmap;
        logic [63:0] v;
        wr(A_SEL1, 64'hFFFF_FFFF_DEAD_BEEF);
        rd(A_SEL1, v); chk("R12 select1 readback", v, 64'h0000_0000_DEAD_BEEF);
        wr(A_GLB, '1);
        rd(A_GLB, v);  chk("R12 enable mask", v, 64'h0000_0007_0000_0003);
        wr(A_GLB, 0);
        wr(A_SEL1, 0);
        wr(A_C1, 64'h1234);
        rd(A_C1, v);   chk("R12 counter load", v, 64'h1234);
    endtask

    task automatic t_count;
        logic [63:0] v;
        wr(A_C0, 0); wr(A_C1, 0); wr(A_F1, 0);
        wr(A_GLB, 64'h0000_0002_0000_0001);
        gp_event = 2'b11; fix_event = 3'b111;
        repeat (5) @(negedge clk);
        gp_event = 0; fix_event = 0;
        @(negedge clk);
        rd(A_C0, v); chk("R2 gp0 enabled", v, 5);
        rd(A_C1, v); chk("R2 gp1 disabled", v, 0);
        rd(A_F1, v); chk("R2 fixed1 enabled", v, 5);
        rd(A_F0, v); chk("R2 fixed0 disabled", v, 0);
        wr(A_GLB, 0);
    endtask

    task automatic t_gp_irq;
        logic [63:0] v;
        int base;
        wr(A_SEL0, 64'h0010_0000);
        wr(A_C0, {16'd0, ALL1 - 48'd1});
        wr(A_GLB, 64'h1);
        base = irq_seen;
        gp_event[0] = 1'b1;
        @(negedge clk); chk("R4 no irq before wrap", {63'd0, pmi_irq}, 0);
        @(negedge clk); chk("R4 irq after wrap", {63'd0, pmi_irq}, 1);
        @(negedge clk); chk("R4 irq one cycle", {63'd0, pmi_irq}, 0);
        gp_event = 0;
        rd(A_GLB, v);  chk("R4 enables cleared", v, 0);
        rd(A_C0, v);   chk("R9 frozen counter held", v, 0);
        rd(A_STAT, v); chk("R3 gp0 status", v, 64'h1);
        chk("R4 single pulse", 64'(irq_seen - base), 1);
        wr(A_CLR, '1);
        wr(A_SEL0, 0);
    endtask

    task automatic t_gp_noirq;
        logic [63:0] v;
        int base;
        wr(A_C1, {16'd0, ALL1});
        wr(A_GLB, 64'h2);
        base = irq_seen;
        gp_event[1] = 1'b1;
        @(negedge clk);
        gp_event = 0;
        @(negedge clk);
        rd(A_C1, v);   chk("R6 wrapped to zero", v, 0);
        rd(A_STAT, v); chk("R6 status set", v, 64'h2);
        rd(A_GLB, v);  chk("R6 enables kept", v, 64'h2);
        chk("R6 no irq", 64'(irq_seen - base), 0);
        wr(A_GLB, 0);
        wr(A_CLR, '1);
    endtask

    task automatic t_fixed;
        logic [63:0] v;
        int base;
        wr(A_FIX, 64'h807);
        wr(A_F0, {16'd0, ALL1});
        wr(A_F2, {16'd0, ALL1});
        wr(A_GLB, 64'h0000_0005_0000_0000);
        base = irq_seen;
        fix_event = 3'b001;
        @(negedge clk);
        fix_event = 0;
        @(negedge clk);
        rd(A_STAT, v); chk("R5 fixed0 status", v, 64'h0000_0001_0000_0000);
        rd(A_GLB, v);  chk("R5 low field bits no freeze", v, 64'h0000_0005_0000_0000);
        chk("R5 low field bits no irq", 64'(irq_seen - base), 0);
        fix_event = 3'b100;
        @(negedge clk); chk("R5 fixed2 irq", {63'd0, pmi_irq}, 1);
        fix_event = 0;
        rd(A_GLB, v);  chk("R5 fixed2 freeze", v, 0);
        @(negedge clk);
        rd(A_STAT, v); chk("R3 status sticky", v, 64'h0000_0005_0000_0000);
        wr(A_CLR, 64'h0000_0004_0000_0000);
        rd(A_STAT, v); chk("R10 selective clear", v, 64'h0000_0001_0000_0000);
        wr(A_CLR, '1);
        rd(A_STAT, v); chk("R10 full clear", v, 0);
        wr(A_FIX, 0);
    endtask

    task automatic t_buffer(input bit branch);
        logic [63:0] v;
        int base;
        string tag;
        tag = branch ? "R8" : "R7";
        wr(A_GLB, 64'h3);
        base = irq_seen;
        if (branch) branch_buf_hit = 1'b1; else sample_buf_hit = 1'b1;
        @(negedge clk); chk({tag, " irq"}, {63'd0, pmi_irq}, 1);
        repeat (5) @(negedge clk);
        chk({tag, " held level one pulse"}, 64'(irq_seen - base), 1);
        rd(A_GLB, v);  chk({tag, " enables cleared"}, v, 0);
        rd(A_STAT, v); chk({tag, " buffer flag"}, v, 64'h4000_0000_0000_0000);
        sample_buf_hit = 0; branch_buf_hit = 0;
        wr(A_CLR, 64'h4000_0000_0000_0000);
        rd(A_STAT, v); chk("R10 buffer flag clear", v, 0);
    endtask

    task automatic t_rearm;
        logic [63:0] v;
        wr(A_C0, 10);
        wr(A_C1, 64'h55);
        gp_event = 2'b01;
        repeat (3) @(negedge clk);
        gp_event = 0;
        rd(A_C0, v); chk("R9 no count while frozen", v, 10);
        wr(A_GLB, 64'h1);
        gp_event = 2'b11;
        repeat (4) @(negedge clk);
        gp_event = 0;
        rd(A_C0, v); chk("R9 count resumes", v, 14);
        rd(A_C1, v); chk("R2 gp1 still disabled", v, 64'h55);
    endtask

    task automatic t_collide;
        logic [63:0] v;
        @(negedge clk);
        bus_we = 1'b1; bus_addr = A_GLB; bus_wdata = 64'h3;
        sample_buf_hit = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        chk("R11 irq on collision", {63'd0, pmi_irq}, 1);
        rd(A_GLB, v); chk("R11 freeze wins", v, 0);
        sample_buf_hit = 1'b0;
        wr(A_CLR, '1);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_count();
        t_gp_irq();
        t_gp_noirq();
        t_fixed();
        t_buffer(1'b0);
        t_buffer(1'b1);
        t_rearm();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule